// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Handler with Storm Deferral

This block sits beside an interrupt redirection table. When an end-of-interrupt (EOI) message arrives carrying a vector, every level-triggered table entry programmed with that vector and still holding its remote-IRR flag is told to drop that flag. If the interrupt line behind such an entry is still asserted and the entry is not masked, the block asks the delivery logic to service the table again, so the still-active level interrupt is sent once more.

A device that never deasserts its line would make this loop endless. To keep it from flooding the system, each pin counts back-to-back re-deliveries. When a pin's count reaches a storm threshold, the count starts over. That re-delivery is then postponed by a fixed number of clock cycles through a shared delay timer rather than being requested at once. A write to any half of a pin's table entry clears that pin's count. The delivery path and the table storage are outside this block: the table contents come in as inputs, and the block returns clear strobes and one service request line.

Top module: `eoi_storm_ctrl`

## Requirements
- R1: An EOI affects only entries whose trigger mode is level (`entry_level`=1) and whose 8-bit vector equals `eoi_vector`; all other pins see no `rirr_clear` and no counter change.
- R2: For an affected entry with `entry_rirr`=1, `rirr_clear` for that pin is high for the one cycle after the EOI edge. An affected entry with `entry_rirr`=0 gets no strobe, and its re-delivery count is kept unchanged.
- R3: When a cleared pin is unmasked and pending, its count rises by one and `service_req` is high for the one cycle after the EOI edge.
- R4: When a cleared pin is masked or not pending, no service is requested for it and its count returns to zero.
- R5: A re-delivery that would bring a pin's count to `STORM_LIMIT` requests no immediate service. It resets the count to zero and arms the delay timer, and `service_req` then pulses once, `DELAY_CYCLES` edges after that EOI edge.
- R6: A storm raised while the timer is running with more than one cycle left does not reload it; only the original expiry produces a request.
- R7: `cnt_clear` for a pin zeroes its count. When it coincides with an EOI for that pin, the count is taken as zero before the EOI is applied.
- R8: All matching pins are handled from a single EOI strobe at once; their clears appear together and their requests merge into one `service_req` pulse.
- R9: Under reset, `rirr_clear` and `service_req` are low, every count is zero and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoi_valid | input | 1 | One-cycle EOI strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| entry_vectors | input | NUM_PINS*VEC_W | Vector field of each table entry, pin 0 in the low bits |
| entry_level | input | NUM_PINS | Trigger mode per entry, 1 = level |
| entry_rirr | input | NUM_PINS | Remote-IRR flag per entry |
| irq_pending | input | NUM_PINS | Pending (line asserted) flag per pin |
| irq_masked | input | NUM_PINS | Mask flag per entry |
| cnt_clear | input | NUM_PINS | Entry-write strobe per pin, clears its count |
| rirr_clear | output | NUM_PINS | Remote-IRR clear strobe per pin |
| service_req | output | 1 | Request to service the table again |

## Verification
The clear strobes and any immediate re-service request are registered, so they are due exactly one edge after the EOI is sampled. A deferred request is due `DELAY_CYCLES` edges after the EOI that raised the storm. The bench drives each cycle's inputs on the falling edge and pushes the outputs it expects after the next rising edge into a queue. A monitor pops one entry per rising edge and compares it a nanosecond later, so every check lands on the cycle its result is due, including the idle cycles that must stay quiet before and after a deferred pulse. The bench runs a small threshold and delay so that storms and timer expiry come within a short run.

// File: rtl/eoi_storm_pkg.sv
// Package: shared types for the EOI broadcast handler.
// Assumes: nothing beyond IEEE 1800-2017.
package eoi_storm_pkg;

    // Per-pin outcome of one EOI evaluation.
    typedef struct packed {
        logic clear;   // remote-IRR to be dropped
        logic now;     // immediate re-delivery wanted
        logic defer;   // storm: re-delivery goes through the timer
    } pin_act_t;

endpackage

// File: rtl/eoi_pin_slice.sv
// Module: eoi_pin_slice
// Evaluates one redirection entry against an EOI and keeps that pin's
// count of back-to-back re-deliveries.
// Assumes: STORM_LIMIT >= 1; cnt_clear is a one-cycle strobe from an entry write.
module eoi_pin_slice
    import eoi_storm_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter int STORM_LIMIT = 10000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic [VEC_W-1:0] entry_vector,
    input  logic             entry_level,
    input  logic             entry_rirr,
    input  logic             pending,
    input  logic             masked,
    input  logic             cnt_clear,
    output pin_act_t         act
);

    localparam int CNT_W = $clog2(STORM_LIMIT + 1);
    localparam logic [CNT_W:0] LIMIT_V = (CNT_W + 1)'(STORM_LIMIT);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   bumped;
    logic             hit;
    logic             redeliver;
    pin_act_t         act_c;

    // Decide the pin's action and its next count for this cycle.
    always_comb begin
        hit          = eoi_valid && entry_level && (entry_vector == eoi_vector);
        act_c.clear  = hit && entry_rirr;
        redeliver    = act_c.clear && !masked && pending;
        base         = cnt_clear ? '0 : count_q;
        bumped       = {1'b0, base} + 1'b1;
        act_c.defer  = redeliver && (bumped >= LIMIT_V);
        act_c.now    = redeliver && !act_c.defer;
        count_d      = base;
        if (act_c.clear) begin
            count_d = act_c.now ? bumped[CNT_W-1:0] : '0;
        end
    end

    assign act = act_c;

    // Hold the re-delivery count.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < LIMIT_V[CNT_W-1:0] || (STORM_LIMIT == (1 << CNT_W) - 1 && count_q != '1));

    // R7
    clear_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clear |=> count_q <= CNT_W'(1));

endmodule

// File: rtl/eoi_defer_timer.sv
// Module: eoi_defer_timer
// Shared countdown that turns a storm into a single late service request.
// Assumes: DELAY_CYCLES >= 2. An arm while running with more than one
// cycle left is ignored; an arm on the expiring cycle reloads.
module eoi_defer_timer #(
    parameter int DELAY_CYCLES = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic busy,
    output logic fire
);

    localparam int TW = $clog2(DELAY_CYCLES + 1);
    localparam logic [TW-1:0] DELAY_V = TW'(DELAY_CYCLES);
    localparam logic [TW-1:0] ONE_V   = TW'(1);

    logic [TW-1:0] remain_q;

    assign busy = (remain_q != '0);
    assign fire = (remain_q == ONE_V);

    // Load on an accepted arm, otherwise count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          remain_q <= '0;
        else if (arm && remain_q <= ONE_V)   remain_q <= DELAY_V;
        else if (busy)                       remain_q <= remain_q - ONE_V;
    end

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && remain_q > ONE_V) |=> remain_q == $past(remain_q) - ONE_V);

    // R5
    arm_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !busy) |=> remain_q == DELAY_V);

endmodule

// File: rtl/eoi_storm_ctrl.sv
// Module: eoi_storm_ctrl (top)
// Broadcasts an EOI over all redirection entries: clears remote-IRR on
// matching level entries, requests re-service for still-active lines and
// defers re-service through a timer when a pin storms.
// Assumes: table contents are stable inputs; outputs are registered.
module eoi_storm_ctrl
    import eoi_storm_pkg::*;
#(
    parameter int NUM_PINS     = 24,
    parameter int VEC_W        = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DELAY_CYCLES = 2500000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    input  logic [NUM_PINS*VEC_W-1:0] entry_vectors,
    input  logic [NUM_PINS-1:0]       entry_level,
    input  logic [NUM_PINS-1:0]       entry_rirr,
    input  logic [NUM_PINS-1:0]       irq_pending,
    input  logic [NUM_PINS-1:0]       irq_masked,
    input  logic [NUM_PINS-1:0]       cnt_clear,
    output logic [NUM_PINS-1:0]       rirr_clear,
    output logic                      service_req
);

    pin_act_t            act [NUM_PINS];
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] now_vec;
    logic [NUM_PINS-1:0] defer_vec;
    logic                defer_busy;
    logic                defer_fire;

    // One evaluation slice per redirection entry.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        eoi_pin_slice #(
            .VEC_W       (VEC_W),
            .STORM_LIMIT (STORM_LIMIT)
        ) i_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .eoi_valid    (eoi_valid),
            .eoi_vector   (eoi_vector),
            .entry_vector (entry_vectors[p*VEC_W +: VEC_W]),
            .entry_level  (entry_level[p]),
            .entry_rirr   (entry_rirr[p]),
            .pending      (irq_pending[p]),
            .masked       (irq_masked[p]),
            .cnt_clear    (cnt_clear[p]),
            .act          (act[p])
        );
        assign clr_vec[p]   = act[p].clear;
        assign now_vec[p]   = act[p].now;
        assign defer_vec[p] = act[p].defer;
    end

    eoi_defer_timer #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (|defer_vec),
        .busy  (defer_busy),
        .fire  (defer_fire)
    );

    // Register the clear strobes and the merged service request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rirr_clear  <= '0;
            service_req <= 1'b0;
        end else begin
            rirr_clear  <= clr_vec;
            service_req <= (|now_vec) || defer_fire;
        end
    end

    // R2
    clear_needs_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rirr_clear) |-> $past(eoi_valid));

    // R3
    req_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        service_req |-> ($past(eoi_valid) || $past(defer_busy)));

    // R1
    clear_needs_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_clear & ~$past(entry_level)) == '0);

endmodule

// File: tb/test_eoi_storm_ctrl.sv
module test_eoi_storm_ctrl;

    localparam int NP = 4;
    localparam int LIM = 4;
    localparam int DLY = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic [31:0]   vecs = {8'h30, 8'h41, 8'h30, 8'h30};
    logic [NP-1:0] level = 4'b1101;
    logic [NP-1:0] rirr = 4'b1111;
    logic [NP-1:0] pend = 4'b1111;
    logic [NP-1:0] msk = 4'b0000;
    logic [NP-1:0] cclr = 4'b0000;
    logic [NP-1:0] rirr_clear;
    logic          service_req;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [NP-1:0] clr;
        logic          req;
        string         tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #2 clk = ~clk;

    eoi_storm_ctrl #(
        .NUM_PINS(NP), .VEC_W(8), .STORM_LIMIT(LIM), .DELAY_CYCLES(DLY)
    ) i_eoi_storm_ctrl (
        .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .entry_vectors(vecs), .entry_level(level), .entry_rirr(rirr),
        .irq_pending(pend), .irq_masked(msk), .cnt_clear(cclr),
        .rirr_clear(rirr_clear), .service_req(service_req)
    );

    // Driver: apply one cycle of inputs and queue the outputs due after the next edge.
    task automatic step(input logic ev, input logic [7:0] vec, input logic [NP-1:0] cc,
                        input logic [NP-1:0] xclr, input logic xreq, input string tag);
        eoi_valid  = ev;
        eoi_vector = vec;
        cclr       = cc;
        q.push_back('{xclr, xreq, tag});
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic xreq_last, input string tag);
        for (int i = 0; i < n; i++)
            step(1'b0, 8'h00, 4'b0000, 4'b0000, (i == n - 1) ? xreq_last : 1'b0, tag);
    endtask

    // Monitor: pop one expectation per rising edge and compare just after it.
    always @(posedge clk) begin
        #1;
        if (q.size() != 0) begin
            e = q.pop_front();
            checks++;
            if (rirr_clear !== e.clr || service_req !== e.req) begin
                errors++;
                $display("FAIL %s: clr=%b req=%b expected clr=%b req=%b",
                         e.tag, rirr_clear, service_req, e.clr, e.req);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rirr_clear !== 4'b0000 || service_req !== 1'b0) begin
            errors++;
            $display("FAIL R9: clr=%b req=%b expected clr=0000 req=0", rirr_clear, service_req);
        end
        rst_n = 1'b1;

        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R1 R3 R8 two level pins");
        step(1, 8'h41, 4'b0000, 4'b0100, 1, "R1 other vector");
        step(1, 8'h55, 4'b0000, 4'b0000, 0, "R1 no match");
        pend[3] = 1'b0;
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R4 not pending");
        rirr[0] = 1'b0;
        step(1, 8'h30, 4'b0000, 4'b1000, 0, "R2 rirr already clear");
        rirr[0] = 1'b1;
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R2 count kept");
        step(1, 8'h30, 4'b0000, 4'b1001, 0, "R5 R9 storm on fourth");
        for (int k = 0; k < 3; k++)
            step(1, 8'h30, 4'b0000, 4'b1001, 1, "R5 count restarted");
        step(1, 8'h30, 4'b0000, 4'b1001, 0, "R6 storm while busy");
        idle(16, 1'b1, "R5 deferred request");
        idle(10, 1'b0, "R6 no second expiry");

        msk[2] = 1'b1;
        step(1, 8'h41, 4'b0000, 4'b0100, 0, "R4 masked");
        msk[2] = 1'b0;

        for (int k = 0; k < 3; k++)
            step(1, 8'h30, 4'b0000, 4'b1001, 1, "R7 build count");
        step(0, 8'h00, 4'b0001, 4'b0000, 0, "R7 clear strobe");
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R7 after clear");
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R7 count two");
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R7 count three");
        step(1, 8'h30, 4'b0001, 4'b1001, 1, "R7 clear with EOI");
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R7 count two again");
        step(1, 8'h30, 4'b0000, 4'b1001, 1, "R7 count three again");
        step(1, 8'h30, 4'b0000, 4'b1001, 0, "R7 R5 storm");
        idle(20, 1'b1, "R5 deferred after clear");
        idle(3, 1'b0, "R5 quiet");

        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule